// File: doc/BRIEF.md
# Memory-mapped GPIO port controller with pin interrupts

This block controls one port of up to 32 general-purpose pins behind a plain 32-bit register bus made of an address, a write strobe, write data and combinational read data. Software owns an output latch and a per-pin direction vector. It can also flip individual output bits without a read-modify-write cycle by using a pair of set and clear ports. Pin inputs pass through a two-flop synchronizer and then an optional per-pin debounce filter. The filtered value can be read back.

Each pin has its own interrupt detector. Three configuration vectors select the trigger for each pin: a trigger-kind vector (level or edge), a polarity vector, and an any-edge vector. Together they give level-high, level-low, rising, falling or any-transition detection. Edge events latch a sticky pending bit that software acknowledges by writing ones. In level mode the pending bit tracks the qualified input. A single interrupt line combines every pending pin that is enabled and not masked. Two pull-configuration words are held as plain storage for the pad ring.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, the registers at 0x00 (output), 0x08 (direction), 0x20 (interrupt enable), 0x2C (mask) and 0x24 (pending status) all read 0, and `pin_out`, `pin_oe` and `irq` are 0.
- R2: The word written to 0x00 is read back from 0x00 and appears on `pin_out`. The word written to 0x08 is read back and drives `pin_oe`, where a 1 makes that pin an output.
- R3: Writing to 0x10 sets the output bits where the word holds 1. Writing to 0x14 clears the output bits where the word holds 1. Bits written as 0 keep their value, and both addresses read as 0.
- R4: Address 0x04 returns the conditioned input. With debounce bypassed, a change on `pin_in` shows up there three clock edges later and not sooner.
- R5: With bit 1 at 0x34 (level kind), the pending bit follows the input: active high when the 0x3C bit is 0, active low when it is 1. An acknowledge cannot clear it while the level stays active.
- R6: With bit 0 at 0x34 (edge kind) and 0 at 0x38, a 0x3C bit of 0 latches rising edges and 1 latches falling edges. A 0x38 bit of 1 latches every transition whatever 0x3C holds. The pending bit is visible four edges after the pin changes.
- R7: Writing 1 to a bit of 0x30 clears that pin's edge-pending bit. Bits written as 0 leave pending bits unchanged.
- R8: A pin whose bit at 0x20 is 0 never becomes pending.
- R9: `irq` is the OR of the pending bits that are enabled and have a 0x2C bit of 0. A mask bit of 1 keeps the pin off `irq`, and 0x24 still shows it as pending.
- R10: A pin with its bit set at 0x40 accepts a new input value only after the synchronized input has differed for D consecutive edges, where D is the value at 0x44. A shorter glitch is dropped, and D of 0 or 1 gives the bypass timing.
- R11: Addresses 0x18 and 0x1C are read/write storage. Any address not listed reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 8 | Byte address of the register |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output latch value |
| pin_oe | output | 32 | Output enable per pin, 1 drives |
| irq | output | 1 | Combined interrupt request |

## Verification
A corrupted trigger-configuration decode shows up in the pending status exactly four edges after a pin moves. The bench reads the status at that edge for every trigger mode, on pins at both ends of the port and in its middle. A stale or mis-prioritized pending bit shows up the cycle after an acknowledge or mask write, either in the status word or on `irq`. Debounce counter faults shift the cycle in which the input word changes, so the bench samples one edge before and one edge at the expected acceptance. Faults in the set/clear logic are exposed by a pseudo-random sequence of set and clear writes checked against a running model after every write.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned BUS_W  = 32;

  localparam logic [ADDR_W-1:0] OFS_OUT   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_IN    = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_DIR   = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_SET   = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_CLR   = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_PEN   = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_PSEL  = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_IEN   = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 8'h2C;
  localparam logic [ADDR_W-1:0] OFS_ACK   = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_KIND  = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_ANY   = 8'h38;
  localparam logic [ADDR_W-1:0] OFS_POL   = 8'h3C;
  localparam logic [ADDR_W-1:0] OFS_DBEN  = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_DBDIV = 8'h44;
endpackage

// File: rtl/gpio_in_cond.sv
// Input conditioning: two-flop synchronizer followed by a per-pin debounce
// filter. Both paths end in the same filter flop, so bypass adds no skew.
module gpio_in_cond #(
  parameter int unsigned NPIN  = 32,
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPIN-1:0]  pin_async,
  input  logic [NPIN-1:0]  db_en,
  input  logic [DIV_W-1:0] db_div,
  output logic [NPIN-1:0]  filt_o
);
  localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1);

  logic [NPIN-1:0] s1_q, s2_q;
  logic            div_bypass;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= pin_async;
      s2_q <= s1_q;
    end
  end

  assign div_bypass = (db_div <= DIV_ONE);

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic [DIV_W-1:0] cnt_q, cnt_d;
    logic             f_q, f_d;

    always_comb begin
      cnt_d = cnt_q;
      f_d   = f_q;
      if (!db_en[i] || div_bypass) begin
        f_d   = s2_q[i];
        cnt_d = '0;
      end else if (s2_q[i] == f_q) begin
        cnt_d = '0;
      end else if (cnt_q == db_div - DIV_ONE) begin
        f_d   = s2_q[i];
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + DIV_ONE;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
        f_q   <= 1'b0;
      end else begin
        cnt_q <= cnt_d;
        f_q   <= f_d;
      end
    end

    assign filt_o[i] = f_q;
  end

  // R10: the filter only ever takes a value the synchronizer presented.
  a_r10_accept_seen: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((filt_o ^ $past(filt_o)) & (filt_o ^ $past(s2_q))) == '0));
endmodule

// File: rtl/gpio_irq_unit.sv
// Per-pin trigger detection and pending state.
module gpio_irq_unit #(
  parameter int unsigned NPIN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] filt_i,
  input  logic [NPIN-1:0] kind_i,
  input  logic [NPIN-1:0] any_i,
  input  logic [NPIN-1:0] pol_i,
  input  logic [NPIN-1:0] en_i,
  input  logic [NPIN-1:0] ack_i,
  output logic [NPIN-1:0] pend_o
);
  logic [NPIN-1:0] prev_q;
  logic [NPIN-1:0] pend_q, pend_d;
  logic [NPIN-1:0] rise, fall, flip, edge_hit, lvl_hit;

  always_comb begin
    rise     = filt_i & ~prev_q;
    fall     = ~filt_i & prev_q;
    flip     = filt_i ^ prev_q;
    edge_hit = (any_i & flip) | (~any_i & ~pol_i & rise) | (~any_i & pol_i & fall);
    lvl_hit  = filt_i ^ pol_i;
    pend_d   = (kind_i & lvl_hit & en_i)
             | (~kind_i & ((pend_q & ~ack_i) | (edge_hit & en_i)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= filt_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  // R8: no pin can newly become pending while its enable was off.
  a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(en_i)) == '0));

  // R7: an acknowledged edge pin with no fresh event is clear next cycle.
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(ack_i & ~kind_i & ~(edge_hit & en_i))) == '0));

  // R5: a level pin that is disabled is never left pending.
  a_r5_level_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(kind_i & ~en_i)) == '0));
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPIN  = 32,
  parameter int unsigned DIV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe,
  output logic              irq
);
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  logic [NPIN-1:0]  out_q, out_d, dir_q, dir_d, pen_q, pen_d, psel_q, psel_d;
  logic [NPIN-1:0]  ien_q, ien_d, msk_q, msk_d, kind_q, kind_d;
  logic [NPIN-1:0]  any_q, any_d, pol_q, pol_d, dben_q, dben_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [NPIN-1:0]  wvec, ack_vec, filt, pend;

  assign wvec    = bus_wdata[NPIN-1:0];
  assign ack_vec = (bus_we && bus_addr == OFS_ACK) ? wvec : '0;

  always_comb begin
    out_d  = out_q;  dir_d  = dir_q;  pen_d = pen_q;  psel_d = psel_q;
    ien_d  = ien_q;  msk_d  = msk_q;  kind_d = kind_q; any_d = any_q;
    pol_d  = pol_q;  dben_d = dben_q; div_d = div_q;
    if (bus_we) begin
      case (bus_addr)
        OFS_OUT:   out_d  = wvec;
        OFS_DIR:   dir_d  = wvec;
        OFS_SET:   out_d  = out_q | wvec;
        OFS_CLR:   out_d  = out_q & ~wvec;
        OFS_PEN:   pen_d  = wvec;
        OFS_PSEL:  psel_d = wvec;
        OFS_IEN:   ien_d  = wvec;
        OFS_MASK:  msk_d  = wvec;
        OFS_KIND:  kind_d = wvec;
        OFS_ANY:   any_d  = wvec;
        OFS_POL:   pol_d  = wvec;
        OFS_DBEN:  dben_d = wvec;
        OFS_DBDIV: div_d  = bus_wdata[DIV_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      out_q <= '0; dir_q <= '0; pen_q <= '0; psel_q <= '0;
      ien_q <= '0; msk_q <= '0; kind_q <= '0; any_q <= '0;
      pol_q <= '0; dben_q <= '0; div_q <= '0;
    end else begin
      out_q <= out_d; dir_q <= dir_d; pen_q <= pen_d; psel_q <= psel_d;
      ien_q <= ien_d; msk_q <= msk_d; kind_q <= kind_d; any_q <= any_d;
      pol_q <= pol_d; dben_q <= dben_d; div_q <= div_d;
    end
  end

  gpio_in_cond #(.NPIN(NPIN), .DIV_W(DIV_W)) u_in (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .pin_async (pin_in),
    .db_en     (dben_q),
    .db_div    (div_q),
    .filt_o    (filt)
  );

  gpio_irq_unit #(.NPIN(NPIN)) u_irq (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .filt_i (filt),
    .kind_i (kind_q),
    .any_i  (any_q),
    .pol_i  (pol_q),
    .en_i   (ien_q),
    .ack_i  (ack_vec),
    .pend_o (pend)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_OUT:   bus_rdata[NPIN-1:0]  = out_q;
      OFS_IN:    bus_rdata[NPIN-1:0]  = filt;
      OFS_DIR:   bus_rdata[NPIN-1:0]  = dir_q;
      OFS_PEN:   bus_rdata[NPIN-1:0]  = pen_q;
      OFS_PSEL:  bus_rdata[NPIN-1:0]  = psel_q;
      OFS_IEN:   bus_rdata[NPIN-1:0]  = ien_q;
      OFS_STAT:  bus_rdata[NPIN-1:0]  = pend;
      OFS_MASK:  bus_rdata[NPIN-1:0]  = msk_q;
      OFS_KIND:  bus_rdata[NPIN-1:0]  = kind_q;
      OFS_ANY:   bus_rdata[NPIN-1:0]  = any_q;
      OFS_POL:   bus_rdata[NPIN-1:0]  = pol_q;
      OFS_DBEN:  bus_rdata[NPIN-1:0]  = dben_q;
      OFS_DBDIV: bus_rdata[DIV_W-1:0] = div_q;
      default: ;
    endcase
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
  assign irq     = |(pend & ien_q & ~msk_q);

  // R3: a set write forces ones and leaves the other bits alone.
  a_r3_set_ones: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bus_we && bus_addr == OFS_SET) |=>
      ((pin_out & $past(wvec)) == $past(wvec)) &&
      ((pin_out & ~$past(wvec)) == ($past(pin_out) & ~$past(wvec))));

  // R3: a clear write drops ones and leaves the other bits alone.
  a_r3_clr_ones: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bus_we && bus_addr == OFS_CLR) |=>
      ((pin_out & $past(wvec)) == '0) &&
      ((pin_out & ~$past(wvec)) == ($past(pin_out) & ~$past(wvec))));

  // R9: with every pin masked the request line stays low.
  a_r9_mask_blocks: assert property (@(posedge clk) disable iff (!rst_i_n)
    (&msk_q) |-> !irq);

  // R1: the first cycle out of reset has no request and no drivers on.
  a_r1_reset_quiet: assert property (@(posedge clk)
    $rose(rst_i_n) |-> (!irq && pin_oe == '0));
endmodule

// File: tb/tb_gpio_port_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_port_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  gpio_port_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.2;
    d = bus_rdata;
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
    end
  end

  initial begin
    logic [31:0] v, model, lfsr, bit_p;
    bus_addr = 8'h00; bus_we = 1'b0; bus_wdata = '0; pin_in = '0;
    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(4);

    // R1 reset state
    rd(8'h00, v); chk("R1 out", v, 0);
    rd(8'h08, v); chk("R1 dir", v, 0);
    rd(8'h20, v); chk("R1 ien", v, 0);
    rd(8'h2C, v); chk("R1 mask", v, 0);
    rd(8'h24, v); chk("R1 stat", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 pin_out", pin_out, 0);
    chk("R1 pin_oe", pin_oe, 0);

    // R2 output and direction
    wr(8'h00, 32'hA5C3_0F96);
    rd(8'h00, v); chk("R2 out read", v, 32'hA5C3_0F96);
    chk("R2 pin_out", pin_out, 32'hA5C3_0F96);
    wr(8'h08, 32'h0FF0_1234);
    rd(8'h08, v); chk("R2 dir read", v, 32'h0FF0_1234);
    chk("R2 pin_oe", pin_oe, 32'h0FF0_1234);

    // R3 set/clear sweep against a running model
    model = 32'hA5C3_0F96;
    lfsr  = 32'h1357_9BDF;
    for (int k = 0; k < 24; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (k[0]) begin wr(8'h14, lfsr); model = model & ~lfsr; end
      else      begin wr(8'h10, lfsr); model = model | lfsr;  end
      chk("R3 set/clear", pin_out, model);
    end
    rd(8'h10, v); chk("R3 set reads 0", v, 0);
    rd(8'h14, v); chk("R3 clr reads 0", v, 0);

    // R4 input latency with bypass
    pin_in = 32'h8001_2480;
    tick(2);
    rd(8'h04, v); chk("R4 in before", v, 0);
    tick(1);
    rd(8'h04, v); chk("R4 in after", v, 32'h8001_2480);
    pin_in = '0;
    tick(4);

    // R5/R6/R9 trigger mode sweep over several pins
    for (int m = 0; m < 6; m++) begin
      logic kind, anyb, pol;
      logic e_hi, e_ack, e_lo;
      kind = (m < 2);
      anyb = (m >= 4);
      pol  = (m == 1) || (m == 3) || (m == 5);
      e_hi  = kind ? ~pol : (anyb | ~pol);
      e_ack = kind ? ~pol : 1'b0;
      e_lo  = kind ? pol  : (anyb | pol);
      for (int q = 0; q < 4; q++) begin
        int p;
        p = (q == 0) ? 0 : (q == 1) ? 9 : (q == 2) ? 22 : 31;
        bit_p = 32'h1 << p;
        wr(8'h34, kind ? bit_p : 32'h0);
        wr(8'h38, anyb ? bit_p : 32'h0);
        wr(8'h3C, pol  ? bit_p : 32'h0);
        wr(8'h20, bit_p);
        wr(8'h30, 32'hFFFF_FFFF);
        pin_in[p] = 1'b1;
        tick(4);
        rd(8'h24, v); chk("R5/R6 after rise", v, e_hi ? bit_p : 32'h0);
        chk("R9 irq after rise", {31'b0, irq}, {31'b0, e_hi});
        wr(8'h30, bit_p);
        rd(8'h24, v); chk("R5/R7 after ack", v, e_ack ? bit_p : 32'h0);
        pin_in[p] = 1'b0;
        tick(4);
        rd(8'h24, v); chk("R5/R6 after fall", v, e_lo ? bit_p : 32'h0);
      end
    end

    // back to all rising-edge, clear everything
    wr(8'h34, 0); wr(8'h38, 0); wr(8'h3C, 0);
    wr(8'h30, 32'hFFFF_FFFF);

    // R6 edge latency: not yet at three edges, set at four
    wr(8'h20, 32'h0000_0004);
    pin_in[2] = 1'b1;
    tick(3);
    rd(8'h24, v); chk("R6 latency early", v, 0);
    tick(1);
    rd(8'h24, v); chk("R6 latency on time", v, 32'h0000_0004);
    pin_in[2] = 1'b0;
    wr(8'h30, 32'h0000_0004);
    tick(4);
    wr(8'h30, 32'hFFFF_FFFF);

    // R8 disabled pin never pending
    wr(8'h20, 32'h0);
    pin_in[4] = 1'b1;
    tick(5);
    rd(8'h24, v); chk("R8 disabled stat", v, 0);
    chk("R8 disabled irq", {31'b0, irq}, 0);
    wr(8'h20, 32'h0000_0010);
    tick(2);
    rd(8'h24, v); chk("R8 enable later stat", v, 0);
    pin_in[4] = 1'b0;
    tick(4);

    // R7 zero bits of acknowledge, R9 mask
    wr(8'h20, 32'h0000_0040);
    pin_in[6] = 1'b1;
    tick(4);
    wr(8'h30, 32'hFFFF_FFBF);
    rd(8'h24, v); chk("R7 zero ack keeps", v, 32'h0000_0040);
    chk("R9 irq unmasked", {31'b0, irq}, 1);
    wr(8'h2C, 32'h0000_0040);
    chk("R9 irq masked", {31'b0, irq}, 0);
    rd(8'h24, v); chk("R9 stat while masked", v, 32'h0000_0040);
    wr(8'h2C, 32'h0);
    chk("R9 irq unmasked again", {31'b0, irq}, 1);
    wr(8'h30, 32'h0000_0040);
    chk("R7 ack drops irq", {31'b0, irq}, 0);
    pin_in[6] = 1'b0;
    tick(4);
    wr(8'h30, 32'hFFFF_FFFF);
    wr(8'h20, 32'h0);

    // R10 debounce
    wr(8'h40, 32'h0000_1000);
    wr(8'h44, 32'd5);
    pin_in[12] = 1'b1;
    pin_in[13] = 1'b1;
    tick(3);
    rd(8'h04, v); chk("R10 plain pin immediate", v & 32'h3000, 32'h2000);
    tick(3);
    rd(8'h04, v); chk("R10 filtered early", v & 32'h1000, 32'h0);
    tick(1);
    rd(8'h04, v); chk("R10 filtered accepted", v & 32'h1000, 32'h1000);
    pin_in[12] = 1'b0;
    tick(3);
    pin_in[12] = 1'b1;
    tick(1);
    for (int k = 0; k < 10; k++) begin
      rd(8'h04, v); chk("R10 glitch dropped", v & 32'h1000, 32'h1000);
      tick(1);
    end
    wr(8'h44, 32'd0);
    pin_in[12] = 1'b0;
    pin_in[13] = 1'b0;
    tick(3);
    rd(8'h04, v); chk("R10 div zero bypass", v & 32'h3000, 32'h0);
    wr(8'h40, 32'h0);

    // R11 pull storage and unused addresses
    wr(8'h18, 32'h1234_5678);
    wr(8'h1C, 32'hCAFE_F00D);
    rd(8'h18, v); chk("R11 pull en", v, 32'h1234_5678);
    rd(8'h1C, v); chk("R11 pull sel", v, 32'hCAFE_F00D);
    rd(8'h00, model);
    for (int k = 0; k < 4; k++) begin
      logic [7:0] a;
      a = (k == 0) ? 8'h0C : (k == 1) ? 8'h28 : (k == 2) ? 8'h48 : 8'hFC;
      wr(a, 32'hFFFF_FFFF);
      rd(a, v); chk("R11 unused reads 0", v, 0);
    end
    rd(8'h00, v); chk("R11 out untouched", v, model);
    rd(8'h18, v); chk("R11 pull untouched", v, 32'h1234_5678);
    chk("R11 irq untouched", {31'b0, irq}, 0);

    done = 1'b1;
    summary();
  end
endmodule